// File: doc/BRIEF.md
# Integer ALU with set-on-condition

This block is the purely combinational integer execution stage of a register-register load/store pipeline. It takes two operands, a four-bit operation code and a signed/unsigned select. From these it produces a result word, an overflow trap flag and a zero flag. The operations are:

- add and subtract
- bitwise AND, OR and XOR
- left logical, right logical and right arithmetic shifts
- a load-high-immediate that places the second operand's low half in the upper half of the result
- six signed comparisons that write 1 or 0 into the result

Only signed addition and subtraction can raise the trap. The unsigned variants produce the same sum and never trap.

The zero flag reports whether the first operand is all zeros. The branch unit uses it to decide a branch-on-zero or a branch-on-nonzero against one register. The comparisons share the adder in subtract mode, so one carry chain serves arithmetic and every ordering test. The word width is a parameter (default 32), and the shift amount width and the half-word split are derived from it.

Top module: `int_alu`

## Requirements
- R1: Code 0 yields a_i + b_i and code 1 yields a_i - b_i, both modulo 2^W, for either setting of sgn_i.
- R2: With sgn_i = 1, ovf_o is 1 only in two cases. For code 0, both operands have the same sign bit and the result's sign bit differs from it. For code 1, the operands' sign bits differ and the result's sign bit differs from a_i's. ovf_o is 0 for every other code.
- R3: With sgn_i = 0, ovf_o is 0 for all operands and codes.
- R4: Code 2 yields a_i & b_i, code 3 yields a_i | b_i and code 4 yields a_i ^ b_i.
- R5: Code 5 shifts a_i left logically, code 6 shifts it right logically, and code 7 shifts it right with copies of bit W-1 filled in. The shift amount is the low log2(W) bits of b_i, and the other bits of b_i are ignored.
- R6: Code 8 places b_i[W/2-1:0] in result bits W-1..W/2 and clears bits W/2-1..0.
- R7: The six compare codes treat both operands as two's complement and ignore sgn_i. They are: 9 less-than, 10 greater-than, 11 less-or-equal, 12 greater-or-equal, 13 equal and 14 not-equal. Each puts 1 in result bit 0 when its condition holds and 0 otherwise, and all other result bits are 0.
- R8: sgn_i has no effect on res_o for any code.
- R9: zero_o is 1 exactly when a_i is all zeros, for every code.
- R10: Code 15 is reserved and yields a zero result with ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, also the register tested by zero_o |
| b_i | input | W | Second operand, shift amount or immediate |
| op_i | input | 4 | Operation code |
| sgn_i | input | 1 | 1 selects signed add/subtract with overflow trap |
| res_o | output | W | Result word |
| ovf_o | output | 1 | Signed overflow trap |
| zero_o | output | 1 | a_i equals zero |

## Verification
The block holds no state, so any internal fault appears at the ports in the same evaluation as the stimulus that exposes it. The faults that matter are a wrong adder mode, a misrouted shifter stage or a swapped compare decode. A wrong adder mode corrupts subtraction and all six compares at once. A broken shifter stage shows only for shift amounts whose matching bit is set. Treating the compares as unsigned shows only when the operands' signs differ. For these reasons the sweep uses an 8-bit configuration and covers every code, both settings of sgn_i and a dense operand grid with the sign-boundary values added.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRL = 4'd6,
        OP_SRA = 4'd7,
        OP_LHI = 4'd8,
        OP_SLT = 4'd9,
        OP_SGT = 4'd10,
        OP_SLE = 4'd11,
        OP_SGE = 4'd12,
        OP_SEQ = 4'd13,
        OP_SNE = 4'd14,
        OP_RSV = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic lt;
        logic eq;
    } cmp_flags_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic is_compare(alu_op_e op);
        return (op >= OP_SLT) && (op <= OP_SNE);
    endfunction

    function automatic logic cond_hit(alu_op_e op, cmp_flags_t f);
        logic r;
        case (op)
            OP_SLT:  r = f.lt;
            OP_SGT:  r = !f.lt && !f.eq;
            OP_SLE:  r = f.lt || f.eq;
            OP_SGE:  r = !f.lt;
            OP_SEQ:  r = f.eq;
            OP_SNE:  r = !f.eq;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         sovf_o
);
    logic [W-1:0] b_eff;

    assign b_eff  = sub_i ? ~b_i : b_i;
    assign sum_o  = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    assign sovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W = 32
) (
    input  logic [W-1:0]         a_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  logic                 left_i,
    input  logic                 arith_i,
    output logic [W-1:0]         y_o
);
    localparam int SHW = $clog2(W);

    logic [W-1:0] a_rev;
    logic [W-1:0] r_rev;
    logic [W-1:0] stg [0:SHW];
    logic         fill;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign a_rev[i] = a_i[W-1-i];
        assign r_rev[i] = stg[SHW][W-1-i];
    end

    assign fill   = arith_i & ~left_i & a_i[W-1];
    assign stg[0] = left_i ? a_rev : a_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stg[k+1] = amt_i[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
    end

    assign y_o = left_i ? r_rev : stg[SHW];
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            sgn_i,
    output logic [W-1:0]    res_o,
    output logic            ovf_o,
    output logic            zero_o
);
    localparam int SHW  = $clog2(W);
    localparam int HALF = W / 2;

    alu_op_e      op;
    logic         use_sub;
    logic [W-1:0] sum;
    logic         sovf;
    cmp_flags_t   flags;
    logic [W-1:0] shv;

    assign op      = alu_op_e'(op_i);
    assign use_sub = (op != OP_ADD);

    alu_addsub #(.W(W)) u_add (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (use_sub),
        .sum_o  (sum),
        .sovf_o (sovf)
    );

    assign flags.lt = sum[W-1] ^ sovf;
    assign flags.eq = (sum == '0);

    alu_shift #(.W(W)) u_sh (
        .a_i     (a_i),
        .amt_i   (b_i[SHW-1:0]),
        .left_i  (op == OP_SLL),
        .arith_i (op == OP_SRA),
        .y_o     (shv)
    );

    always_comb begin
        res_o = '0;
        case (op)
            OP_ADD, OP_SUB:          res_o = sum;
            OP_AND:                  res_o = a_i & b_i;
            OP_OR:                   res_o = a_i | b_i;
            OP_XOR:                  res_o = a_i ^ b_i;
            OP_SLL, OP_SRL, OP_SRA:  res_o = shv;
            OP_LHI:                  res_o = {b_i[HALF-1:0], {HALF{1'b0}}};
            default: begin
                if (is_compare(op)) res_o = {{(W-1){1'b0}}, cond_hit(op, flags)};
            end
        endcase
    end

    assign ovf_o  = sgn_i & is_arith(op) & sovf;
    assign zero_o = ~|a_i;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   op_i,
    input logic         sgn_i,
    input logic [W-1:0] res_o,
    input logic         ovf_o,
    input logic         zero_o
);
    localparam int HALF = W / 2;

    always_comb begin
        // R2
        ovf_scope_chk: assert (!ovf_o || (sgn_i && (op_i <= 4'd1)))
            else $error("trap outside signed add/sub");
        // R3
        no_overflow_chk: assert (sgn_i || !ovf_o)
            else $error("unsigned op trapped");
        // R7
        cmp_bit_chk: assert (!(op_i >= 4'd9 && op_i <= 4'd14) || (res_o[W-1:1] == '0))
            else $error("compare result wider than one bit");
        // R6
        lhi_half_chk: assert (op_i != 4'd8 ||
                              (res_o[HALF-1:0] == '0 && res_o[W-1:HALF] == b_i[HALF-1:0]))
            else $error("load-high layout wrong");
        // R4
        and_subset_chk: assert (op_i != 4'd2 || ((res_o & ~(a_i & b_i)) == '0))
            else $error("AND set a bit absent from an operand");
        // R9
        zero_or_chk: assert (!(zero_o && op_i == 4'd3) || (res_o == b_i))
            else $error("zero flag set while a_i nonzero");
        // R10
        rsv_quiet_chk: assert (op_i != 4'd15 || (res_o == '0 && !ovf_o))
            else $error("reserved code not quiet");
    end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (op_i),
    .sgn_i  (sgn_i),
    .res_o  (res_o),
    .ovf_o  (ovf_o),
    .zero_o (zero_o)
);

// File: tb/sim_int_alu.sv
module sim_int_alu;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [BW-1:0] a = '0;
    logic [BW-1:0] b = '0;
    logic [3:0]    op = '0;
    logic          sgn = 1'b0;
    logic [BW-1:0] res;
    logic          ovf;
    logic          zero;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    int_alu #(.W(BW)) u0 (
        .a_i    (a),
        .b_i    (b),
        .op_i   (op),
        .sgn_i  (sgn),
        .res_o  (res),
        .ovf_o  (ovf),
        .zero_o (zero)
    );

    task automatic check(string req, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s op=%0d sgn=%0d a=%02h b=%02h actual=%0h expected=%0h",
                     req, op, sgn, a, b, got, exp);
        end
    endtask

    function automatic logic [BW-1:0] pick(int i);
        case (i)
            86: return 8'h01;
            87: return 8'h7F;
            88: return 8'h80;
            89: return 8'h81;
            90: return 8'hFE;
            91: return 8'h40;
            default: return 8'(i * 3);
        endcase
    endfunction

    function automatic logic [BW-1:0] exp_res(logic [3:0] o, logic [BW-1:0] x, logic [BW-1:0] y);
        int sx = int'($signed(x));
        int sy = int'($signed(y));
        case (o)
            4'd0:  return x + y;
            4'd1:  return x - y;
            4'd2:  return x & y;
            4'd3:  return x | y;
            4'd4:  return x ^ y;
            4'd5:  return x << y[2:0];
            4'd6:  return x >> y[2:0];
            4'd7:  return $unsigned($signed(x) >>> y[2:0]);
            4'd8:  return {y[3:0], 4'h0};
            4'd9:  return (sx <  sy) ? 8'd1 : 8'd0;
            4'd10: return (sx >  sy) ? 8'd1 : 8'd0;
            4'd11: return (sx <= sy) ? 8'd1 : 8'd0;
            4'd12: return (sx >= sy) ? 8'd1 : 8'd0;
            4'd13: return (sx == sy) ? 8'd1 : 8'd0;
            4'd14: return (sx != sy) ? 8'd1 : 8'd0;
            default: return 8'd0;
        endcase
    endfunction

    function automatic bit exp_ovf(logic [3:0] o, bit s, logic [BW-1:0] x, logic [BW-1:0] y);
        int sx = int'($signed(x));
        int sy = int'($signed(y));
        int t;
        if (!s || o > 4'd1) return 1'b0;
        t = (o == 4'd0) ? sx + sy : sx - sy;
        return (t > 127) || (t < -128);
    endfunction

    function automatic string req_of(logic [3:0] o, bit s);
        if (s && o > 4'd1 && o != 4'd15) return "R8";
        case (o)
            4'd0, 4'd1:             return "R1";
            4'd2, 4'd3, 4'd4:       return "R4";
            4'd5, 4'd6, 4'd7:       return "R5";
            4'd8:                   return "R6";
            4'd15:                  return "R10";
            default:                return "R7";
        endcase
    endfunction

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #5;
        // idle state: zero operands, add
        check("R1", int'(res), 0);
        check("R3", int'(ovf), 0);
        check("R9", int'(zero), 1);

        for (int s = 0; s < 2; s++) begin
            for (int o = 0; o < 16; o++) begin
                for (int i = 0; i < 92; i++) begin
                    for (int j = 0; j < 92; j++) begin
                        a   = pick(i);
                        b   = pick(j);
                        op  = 4'(o);
                        sgn = s[0];
                        #2;
                        check(req_of(op, sgn), int'(res), int'(exp_res(op, a, b)));
                        check(sgn ? "R2" : "R3", int'(ovf), int'(exp_ovf(op, sgn, a, b)));
                        if (j == 0) check("R9", int'(zero), (a == 0) ? 1 : 0);
                    end
                end
            end
        end

        // upper bits of b ignored by shifts (R5)
        a = 8'hB5; b = 8'hF9; op = 4'd6; sgn = 1'b0;
        #2 check("R5", int'(res), int'(8'hB5 >> 1));
        op = 4'd7;
        #2 check("R5", int'(res), int'(8'hDA));

        done = 1'b1;
        report();
    end

    initial begin
        #3000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end
endmodule